// File: doc/BRIEF.md
# Destination Port Mask Resolver

This block works out the set of egress ports for one Layer 2 frame in a small Ethernet switch. It owns a single table of port bitmaps and reads it three times per frame. The first read fetches a destination set. The second fetches an aggregation set, chosen by the 4-bit link aggregation code. The third fetches a source set, chosen by the ingress port. The block forwards the frame to the ports that appear in all three. Each bitmap has one bit per physical port plus one bit for the CPU port, which sits just above the highest physical port.

The destination row depends on the MAC lookup. If the lookup hit, the row index comes with the request. If it missed, the block uses one of three flood selectors, picked by the frame class. The reserved destination rows are 57 (discard), 58 (CPU), 59 (unknown-unicast flood), 60 (non-IP multicast flood), 61 (IPv4 multicast flood), 62 (IPv6 multicast flood) and 63 (broadcast flood).

Software fills the table rows and the flood selectors through two simple write ports. A table write takes the table for its cycle, so a resolve in progress waits one cycle.

Top module: `pgid_resolver`

## Requirements
- R1: After reset every table row is zero, `dest_mask` is zero and `done` is low. A frame resolved before any row is written gives an empty set.
- R2: The result is the bitwise AND of three rows:
  - the destination row;
  - row 64 + `req_aggr`;
  - row 80 + `req_src`.
- R3: When `req_hit` is 1, the destination row is `req_dest_idx`.
- R4: When `req_hit` is 0, the destination row comes from a flood selector picked by `req_class`:
  - class 0 (unicast) uses selector 0, which resets to 59;
  - class 1 (multicast) uses selector 1, which resets to 60;
  - class 2 and class 3 (broadcast) use selector 2, which resets to 63.
- R5: A write with `fld_we` and `fld_class` 0, 1 or 2 loads `fld_idx` into that selector. A write with `fld_class` 3 is ignored.
- R6: For an accepted request with no table write in flight, `done` is high for exactly one cycle, three clock edges after the edge that sampled the request. `dest_mask` is updated on that same edge and holds until the next `done`.
- R7: Each cycle with `tbl_we` high during a resolve delays the resolve by one cycle. A row written during the resolve is seen by any read of that row that happens later.
- R8: A `req_valid` that arrives while a resolve is in progress is ignored, and the result is that of the request already accepted.
- R9: Bit 10 of every bitmap (bit NUM_PORTS) is the CPU port, and the CPU port's source row is 80 + 10. An ingress number above the CPU port resolves to an empty set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table row write strobe |
| tbl_addr | input | 7 | Row index to write |
| tbl_wdata | input | 11 | Port bitmap to write |
| fld_we | input | 1 | Flood selector write strobe |
| fld_class | input | 2 | Selector to write: 0 unicast, 1 multicast, 2 broadcast |
| fld_idx | input | 6 | Destination row index stored in the selector |
| req_valid | input | 1 | Resolve request |
| req_hit | input | 1 | MAC lookup hit |
| req_dest_idx | input | 6 | Destination row from the matching MAC entry |
| req_class | input | 2 | Frame class: 0 unicast, 1 multicast, 2 or 3 broadcast |
| req_aggr | input | 4 | Link aggregation code |
| req_src | input | 4 | Ingress port number |
| done | output | 1 | One-cycle result strobe |
| dest_mask | output | 11 | Resolved egress port set |

## Verification
The hardest case to reach is a table write that lands in the middle of a resolve and changes the very row the resolve is about to read. The stimulus times the write to the cycle right after the request is accepted. It then checks two things: that `done` arrives one cycle later than usual, and that the result uses the new row contents. Requests held high through a busy resolve are driven the same way, with conflicting field values, to show that only the first request is used.

// File: rtl/pgid_resolver.sv
module pgid_resolver #(
  parameter int NUM_PORTS = 10,
  parameter int DEST_ROWS = 64,
  parameter int AGGR_ROWS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tbl_we,
  input  logic [$clog2(DEST_ROWS+AGGR_ROWS+NUM_PORTS+1)-1:0] tbl_addr,
  input  logic [NUM_PORTS:0]             tbl_wdata,
  input  logic                           fld_we,
  input  logic [1:0]                     fld_class,
  input  logic [$clog2(DEST_ROWS)-1:0]   fld_idx,
  input  logic                           req_valid,
  input  logic                           req_hit,
  input  logic [$clog2(DEST_ROWS)-1:0]   req_dest_idx,
  input  logic [1:0]                     req_class,
  input  logic [$clog2(AGGR_ROWS)-1:0]   req_aggr,
  input  logic [$clog2(NUM_PORTS+1)-1:0] req_src,
  output logic                           done,
  output logic [NUM_PORTS:0]             dest_mask
);
  localparam int PW        = NUM_PORTS + 1;
  localparam int DIW       = $clog2(DEST_ROWS);
  localparam int AGW       = $clog2(AGGR_ROWS);
  localparam int SW        = $clog2(PW);
  localparam int AGGR_BASE = DEST_ROWS;
  localparam int SRC_BASE  = DEST_ROWS + AGGR_ROWS;
  localparam int DEPTH     = SRC_BASE + PW;
  localparam int AW        = $clog2(DEPTH);

  localparam logic [DIW-1:0] UC_RST = DIW'(DEST_ROWS - 5);
  localparam logic [DIW-1:0] MC_RST = DIW'(DEST_ROWS - 4);
  localparam logic [DIW-1:0] BC_RST = DIW'(DEST_ROWS - 1);

  logic [PW-1:0]  tbl [DEPTH];
  logic [DIW-1:0] sel_uc, sel_mc, sel_bc;
  logic [1:0]     phase;
  logic [DIW-1:0] dst_r;
  logic [AGW-1:0] agg_r;
  logic [SW-1:0]  src_r;
  logic [PW-1:0]  acc;
  logic [AW:0]    rd_addr;
  logic [PW-1:0]  rd_row;
  logic           adv;
  logic [DIW-1:0] pick;

  assign pick = req_hit ? req_dest_idx :
                (req_class == 2'd0) ? sel_uc :
                (req_class == 2'd1) ? sel_mc : sel_bc;

  assign rd_addr = (phase == 2'd1) ? (AW+1)'(dst_r) :
                   (phase == 2'd2) ? (AW+1)'(AGGR_BASE) + (AW+1)'(agg_r) :
                                     (AW+1)'(SRC_BASE) + (AW+1)'(src_r);

  assign rd_row = (int'(rd_addr) < DEPTH) ? tbl[rd_addr[AW-1:0]] : '0;
  assign adv    = (phase != 2'd0) && !tbl_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (tbl_we && int'(tbl_addr) < DEPTH) begin
      tbl[tbl_addr] <= tbl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_uc <= UC_RST;
      sel_mc <= MC_RST;
      sel_bc <= BC_RST;
    end else if (fld_we) begin
      case (fld_class)
        2'd0:    sel_uc <= fld_idx;
        2'd1:    sel_mc <= fld_idx;
        2'd2:    sel_bc <= fld_idx;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= 2'd0;
      dst_r     <= '0;
      agg_r     <= '0;
      src_r     <= '0;
      acc       <= '0;
      dest_mask <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == 2'd0) begin
        if (req_valid) begin
          dst_r <= pick;
          agg_r <= req_aggr;
          src_r <= req_src;
          phase <= 2'd1;
        end
      end else if (adv) begin
        case (phase)
          2'd1: begin acc <= rd_row;       phase <= 2'd2; end
          2'd2: begin acc <= acc & rd_row; phase <= 2'd3; end
          default: begin
            dest_mask <= acc & rd_row;
            done      <= 1'b1;
            phase     <= 2'd0;
          end
        endcase
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dest_mask));

  assert_last_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && !tbl_we) |=> done);

  assert_write_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd0 && tbl_we) |=> ($stable(phase) && !done));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 || phase == 2'd3) |=> (phase != 2'd1));
endmodule

// File: tb/pgid_resolver_tb.sv
module pgid_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 10;
  localparam int PW = NP + 1;
  localparam int DEPTH = 80 + PW;

  logic clk = 0, rst_n = 0;
  logic tbl_we = 0; logic [6:0] tbl_addr = '0; logic [PW-1:0] tbl_wdata = '0;
  logic fld_we = 0; logic [1:0] fld_class = '0; logic [5:0] fld_idx = '0;
  logic req_valid = 0, req_hit = 0; logic [5:0] req_dest_idx = '0;
  logic [1:0] req_class = '0; logic [3:0] req_aggr = '0, req_src = '0;
  logic done; logic [PW-1:0] dest_mask;

  int tests = 0, fails = 0, cyc = 0;
  logic [PW-1:0] model [DEPTH];
  logic [5:0] sel_m [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  pgid_resolver u_dut (.clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .fld_we(fld_we), .fld_class(fld_class), .fld_idx(fld_idx),
    .req_valid(req_valid), .req_hit(req_hit), .req_dest_idx(req_dest_idx),
    .req_class(req_class), .req_aggr(req_aggr), .req_src(req_src),
    .done(done), .dest_mask(dest_mask));

  // each vector: {hit, dest_idx[5:0], class[1:0], aggr[3:0], src[3:0]}
  localparam logic [16:0] VEC [10] = '{
    {1'b1, 6'd3,  2'd0, 4'd0, 4'd0},
    {1'b1, 6'd3,  2'd0, 4'd0, 4'd3},
    {1'b1, 6'd20, 2'd0, 4'd5, 4'd2},
    {1'b1, 6'd59, 2'd0, 4'd7, 4'd0},
    {1'b0, 6'd0,  2'd0, 4'd0, 4'd1},
    {1'b0, 6'd0,  2'd1, 4'd0, 4'd10},
    {1'b0, 6'd0,  2'd2, 4'd0, 4'd4},
    {1'b0, 6'd0,  2'd3, 4'd0, 4'd4},
    {1'b1, 6'd58, 2'd0, 4'd3, 4'd0},
    {1'b1, 6'd57, 2'd0, 4'd0, 4'd0}
  };

  task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] predict(logic hit, logic [5:0] di, logic [1:0] cl,
                                            logic [3:0] ag, logic [3:0] sr);
    logic [5:0] d;
    logic [PW-1:0] s;
    d = hit ? di : sel_m[(cl == 2'd3) ? 2 : cl];
    s = (80 + int'(sr) < DEPTH) ? model[80 + int'(sr)] : '0;
    return model[d] & model[64 + int'(ag)] & s;
  endfunction

  task automatic wr(int a, logic [PW-1:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 7'(a); tbl_wdata = d;
    model[a] = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic wsel(logic [1:0] c, logic [5:0] v);
    @(negedge clk);
    fld_we = 1; fld_class = c; fld_idx = v;
    if (c != 2'd3) sel_m[c] = v;
    @(negedge clk);
    fld_we = 0;
  endtask

  // drives one request, returns the number of negedges until done appears
  task automatic resolve(logic [16:0] v, output int lat);
    @(negedge clk);
    req_valid = 1; {req_hit, req_dest_idx, req_class, req_aggr, req_src} = v;
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
  endtask

  initial begin
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [PW-1:0] e;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    sel_m[0] = 6'd59; sel_m[1] = 6'd60; sel_m[2] = 6'd63;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset mask", dest_mask, '0);
    check("R1 reset done", PW'(done), '0);
    resolve({1'b0, 6'd0, 2'd2, 4'd0, 4'd0}, lat);
    check("R1 empty table result", dest_mask, '0);

    for (int k = 0; k < PW; k++) wr(k, PW'(1) << k);
    wr(20, 11'h0F0); wr(58, 11'h400); wr(59, 11'h3FF); wr(60, 11'h0AA); wr(63, 11'h7FF);
    for (int k = 0; k < 16; k++) wr(64 + k, 11'h7FF);
    wr(64 + 5, 11'h7FD); wr(64 + 7, 11'h7FB);
    for (int k = 0; k < PW; k++) wr(80 + k, 11'h7FF & ~(PW'(1) << k));

    foreach (VEC[n]) begin
      resolve(VEC[n], lat);
      e = predict(VEC[n][16], VEC[n][15:10], VEC[n][9:8], VEC[n][7:4], VEC[n][3:0]);
      check(VEC[n][16] ? "R2 R3 hit vector" : "R2 R4 flood vector", dest_mask, e);
    end

    resolve({1'b1, 6'd63, 2'd0, 4'd0, 4'd10}, lat);
    check("R9 CPU ingress row", dest_mask, 11'h3FF);
    resolve({1'b1, 6'd63, 2'd0, 4'd0, 4'd12}, lat);
    check("R9 ingress above CPU", dest_mask, '0);

    resolve({1'b1, 6'd5, 2'd0, 4'd0, 4'd0}, lat);
    check("R6 latency", PW'(lat), PW'(3));
    check("R6 result", dest_mask, 11'h020);
    @(negedge clk);
    check("R6 done single cycle", PW'(done), '0);
    repeat (3) @(negedge clk);
    check("R6 mask holds", dest_mask, 11'h020);

    wsel(2'd0, 6'd20);
    resolve({1'b0, 6'd0, 2'd0, 4'd0, 4'd0}, lat);
    check("R5 unicast selector rewritten", dest_mask, 11'h0F0);
    wsel(2'd3, 6'd3);
    resolve({1'b0, 6'd0, 2'd2, 4'd0, 4'd0}, lat);
    check("R5 class 3 selector write ignored", dest_mask, 11'h7FE);

    @(negedge clk);
    req_valid = 1; {req_hit, req_dest_idx, req_class, req_aggr, req_src} = {1'b1, 6'd20, 2'd0, 4'd0, 4'd0};
    @(negedge clk);
    req_valid = 0;
    tbl_we = 1; tbl_addr = 7'd20; tbl_wdata = 11'h036; model[20] = 11'h036;
    @(negedge clk);
    tbl_we = 0;
    lat = 1;
    for (int i = 0; i < 12; i++) begin
      if (done) break;
      @(negedge clk);
      lat++;
    end
    check("R7 stalled latency", PW'(lat), PW'(4));
    check("R7 new row used", dest_mask, 11'h036);

    @(negedge clk);
    req_valid = 1; {req_hit, req_dest_idx, req_class, req_aggr, req_src} = {1'b1, 6'd3, 2'd0, 4'd0, 4'd0};
    @(negedge clk);
    {req_hit, req_dest_idx, req_class, req_aggr, req_src} = {1'b1, 6'd63, 2'd0, 4'd0, 4'd1};
    @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 12; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check("R8 busy request ignored", dest_mask, 11'h008);
    repeat (6) @(negedge clk);
    check("R8 no second done", dest_mask, 11'h008);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule